// File: doc/BRIEF.md
# Credit-Controlled Wide Link Framer

This block holds both ends of a short, wide link between two neighbouring switches that share one clock. Each cycle the link carries a 16-bit word, which is the whole flow-control unit, together with a 4-bit forward control field. Going the other way, 4 wires carry a credit count. The transmit end takes packets from a ready/valid source. For each packet it sends a routing-tag flit, then body flits, then a closing end-of-packet flit. On any cycle with nothing to send, it drives an idle flit.

The receive end decodes the flit type on each cycle and buffers legal flits in a small queue. It presents packets on a ready/valid output that marks the first and last beat. It hands buffer space back to the sender as credits. When the receiver has no room, a packet waits in place at the sender instead of being lost.

The two ends have separate link ports. A switch wires the transmit side of one block to the receive side of its neighbour's block.

Top module: `wlink_framer`

## Requirements
- R1: After reset the forward control field is 0 (idle), `src_ready_o`, `dst_valid_o`, `frame_err_o` are low and `rx_credit_o` is 0.
- R2: The control field bits [1:0] give the flit type: 00 idle, 01 routing tag, 10 body, 11 end-of-packet. Bits [3:2] are always 0.
- R3: A packet of N source beats (N ≥ 1) is sent on the link as follows. First a routing-tag flit whose data is `src_tag_i`. Then N−1 body flits. Then one end-of-packet flit that carries the beat marked `src_last_i`. The words keep their order, and each flit appears the cycle after the edge that sends it.
- R4: The transmitter starts with DEPTH credits. Each non-idle flit spends one credit, and `tx_credit_i` adds its value on each clock. The credit count never exceeds DEPTH.
- R5: The transmitter drives idle flits whenever it has no credit or the source has nothing valid.
- R6: The receiver presents each packet in order. The first beat is the tag word with `dst_first_o`=1. The last beat is the end-of-packet word with `dst_last_o`=1. Every other beat has both markers at 0.
- R7: The receiver returns one credit on `rx_credit_o` for each buffered flit it dequeues and for each flit it discards. The credit appears in the cycle after the dequeue or the discard.
- R8: A body or end-of-packet flit that arrives outside an open packet sets `frame_err_o`, which stays set until reset. That flit is discarded and does not reach the output.
- R9: When the output is stalled, the output beat holds steady. The transmitter blocks after DEPTH flits and drops nothing, and resumes when space frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_valid_i | input | 1 | Source beat valid |
| src_ready_o | output | 1 | Source beat accepted |
| src_tag_i | input | 16 | Routing tag of the current packet |
| src_data_i | input | 16 | Source data word |
| src_last_i | input | 1 | Beat is the final word of the packet |
| tx_phit_o | output | 16 | Forward data wires |
| tx_ctl_o | output | 4 | Forward control wires |
| tx_credit_i | input | 4 | Credits returned by the far end |
| rx_phit_i | input | 16 | Incoming data wires |
| rx_ctl_i | input | 4 | Incoming control wires |
| rx_credit_o | output | 4 | Credits returned to the far end |
| dst_valid_o | output | 1 | Output beat valid |
| dst_ready_i | input | 1 | Output beat taken |
| dst_data_o | output | 16 | Output word |
| dst_first_o | output | 1 | Beat is the routing tag |
| dst_last_o | output | 1 | Beat is the end-of-packet word |
| frame_err_o | output | 1 | Sticky framing violation |

## Verification
The bench joins the link in loopback. It sweeps packet lengths from one to six words against three sink patterns: always ready, ready every other cycle, and ready one cycle in four. Single-word packets show that the end-of-packet flit is the only data flit. The longer packets and the slow sinks tell free streaming apart from credit-limited streaming. A fully stalled sink with an eight-word packet checks that exactly DEPTH flits leave before the sender blocks. A phase that injects stray body and end-of-packet flits, followed by a legal packet, separates discarding from buffering and checks that the error flag stays set.

// File: rtl/wlink_pkg.sv
package wlink_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_TAIL = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/wlink_fifo.sv
module wlink_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= bump(wp_q);
      if (rd_i) rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(wr_i) - CW'(rd_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wdata_i;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (!wr_i || rd_i));
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/wlink_tx.sv
module wlink_tx
  import wlink_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTL_W  = 4,
  parameter int CRD_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  input  logic [DATA_W-1:0] src_tag_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_last_i,
  output logic [DATA_W-1:0] phit_o,
  output logic [CTL_W-1:0]  ctl_o,
  input  logic [CRD_W-1:0]  credit_i
);
  localparam int CNT_W = $clog2(DEPTH + 1) + 1;
  localparam int SUM_W = CNT_W + CRD_W;

  logic [CNT_W-1:0]  cred_q;
  logic              open_q;
  logic [DATA_W-1:0] phit_q;
  flit_kind_e        kind_q, kind_d;
  logic              has_cred, send_head, send_beat, sent;
  logic [SUM_W-1:0]  cred_sum;

  assign has_cred    = (cred_q != '0);
  assign send_head   = !open_q && src_valid_i && has_cred;
  assign send_beat   = open_q && src_valid_i && has_cred;
  assign sent        = send_head || send_beat;
  assign src_ready_o = open_q && has_cred;
  assign cred_sum    = SUM_W'(cred_q) + SUM_W'(credit_i) - SUM_W'(sent);

  always_comb begin
    kind_d = FK_IDLE;
    if (send_head)      kind_d = FK_HEAD;
    else if (send_beat) kind_d = src_last_i ? FK_TAIL : FK_BODY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cred_q <= CNT_W'(DEPTH);
      open_q <= 1'b0;
      phit_q <= '0;
      kind_q <= FK_IDLE;
    end else begin
      cred_q <= CNT_W'(cred_sum);
      kind_q <= kind_d;
      phit_q <= send_head ? src_tag_i : (send_beat ? src_data_i : '0);
      if (send_head) open_q <= 1'b1;
      else if (send_beat && src_last_i) open_q <= 1'b0;
    end
  end

  assign phit_o = phit_q;
  assign ctl_o  = {{(CTL_W - 2){1'b0}}, kind_q};

  // R4
  cred_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cred_q <= CNT_W'(DEPTH));
  // R5
  no_cred_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cred_q == '0) |=> (ctl_o == '0));
  // R3
  tail_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == FK_TAIL) |-> !open_q);
  // R3
  head_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == FK_HEAD) |-> open_q);
endmodule

// File: rtl/wlink_rx.sv
module wlink_rx
  import wlink_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTL_W  = 4,
  parameter int CRD_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] phit_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [CRD_W-1:0]  credit_o,
  output logic              dst_valid_o,
  input  logic              dst_ready_i,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_first_o,
  output logic              dst_last_o,
  output logic              frame_err_o
);
  localparam int EW = DATA_W + 2;

  flit_kind_e        kind;
  logic              is_head, is_data, keep, drop, deq, empty, full;
  logic              open_q, err_q;
  logic [CRD_W-1:0]  credit_q;
  logic [EW-1:0]     head_ent;

  assign kind    = flit_kind_e'(ctl_i[1:0]);
  assign is_head = (kind == FK_HEAD);
  assign is_data = (kind == FK_BODY) || (kind == FK_TAIL);
  assign keep    = is_head || (is_data && open_q);
  assign drop    = is_data && !open_q;
  assign deq     = dst_valid_o && dst_ready_i;

  wlink_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (keep),
    .wdata_i ({is_head, kind == FK_TAIL, phit_i}),
    .rd_i    (deq),
    .rdata_o (head_ent),
    .empty_o (empty),
    .full_o  (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= 1'b0;
      err_q    <= 1'b0;
      credit_q <= '0;
    end else begin
      if (is_head) open_q <= 1'b1;
      else if (kind == FK_TAIL) open_q <= 1'b0;
      err_q    <= err_q || drop;
      credit_q <= CRD_W'(deq) + CRD_W'(drop);
    end
  end

  assign dst_valid_o = !empty;
  assign dst_first_o = head_ent[EW-1];
  assign dst_last_o  = head_ent[EW-2];
  assign dst_data_o  = head_ent[DATA_W-1:0];
  assign credit_o    = credit_q;
  assign frame_err_o = err_q;

  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[CTL_W-1:2] == '0);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_o && !dst_ready_i) |=> (dst_valid_o && $stable(dst_data_o)));
  // R4
  space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep |-> (!full || deq));
endmodule

// File: rtl/wlink_framer.sv
module wlink_framer #(
  parameter int DATA_W = 16,
  parameter int CTL_W  = 4,
  parameter int CRD_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  input  logic [DATA_W-1:0] src_tag_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_last_i,
  output logic [DATA_W-1:0] tx_phit_o,
  output logic [CTL_W-1:0]  tx_ctl_o,
  input  logic [CRD_W-1:0]  tx_credit_i,
  input  logic [DATA_W-1:0] rx_phit_i,
  input  logic [CTL_W-1:0]  rx_ctl_i,
  output logic [CRD_W-1:0]  rx_credit_o,
  output logic              dst_valid_o,
  input  logic              dst_ready_i,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_first_o,
  output logic              dst_last_o,
  output logic              frame_err_o
);
  wlink_tx #(.DATA_W(DATA_W), .CTL_W(CTL_W), .CRD_W(CRD_W), .DEPTH(DEPTH)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_valid_i (src_valid_i),
    .src_ready_o (src_ready_o),
    .src_tag_i   (src_tag_i),
    .src_data_i  (src_data_i),
    .src_last_i  (src_last_i),
    .phit_o      (tx_phit_o),
    .ctl_o       (tx_ctl_o),
    .credit_i    (tx_credit_i)
  );

  wlink_rx #(.DATA_W(DATA_W), .CTL_W(CTL_W), .CRD_W(CRD_W), .DEPTH(DEPTH)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phit_i      (rx_phit_i),
    .ctl_i       (rx_ctl_i),
    .credit_o    (rx_credit_o),
    .dst_valid_o (dst_valid_o),
    .dst_ready_i (dst_ready_i),
    .dst_data_o  (dst_data_o),
    .dst_first_o (dst_first_o),
    .dst_last_o  (dst_last_o),
    .frame_err_o (frame_err_o)
  );
endmodule

// File: tb/wlink_framer_test.sv
module wlink_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_valid = 1'b0, src_ready, src_last = 1'b0;
  logic [15:0] src_tag = '0, src_data = '0;
  logic [15:0] tx_phit, rx_phit, dst_data;
  logic [3:0] tx_ctl, rx_ctl, tx_credit, rx_credit;
  logic dst_valid, dst_ready = 1'b0, dst_first, dst_last, frame_err;
  logic inj = 1'b0, blk = 1'b0;
  logic [15:0] inj_phit = '0;
  logic [3:0] inj_ctl = '0;

  assign rx_phit   = inj ? inj_phit : tx_phit;
  assign rx_ctl    = inj ? inj_ctl : tx_ctl;
  assign tx_credit = blk ? 4'd0 : rx_credit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wlink_framer #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_valid_i(src_valid), .src_ready_o(src_ready), .src_tag_i(src_tag),
    .src_data_i(src_data), .src_last_i(src_last),
    .tx_phit_o(tx_phit), .tx_ctl_o(tx_ctl), .tx_credit_i(tx_credit),
    .rx_phit_i(rx_phit), .rx_ctl_i(rx_ctl), .rx_credit_o(rx_credit),
    .dst_valid_o(dst_valid), .dst_ready_i(dst_ready), .dst_data_o(dst_data),
    .dst_first_o(dst_first), .dst_last_o(dst_last), .frame_err_o(frame_err)
  );

  int errs = 0, checks = 0;
  int cred_model = DEPTH, rx_in_cnt = 0, rx_ret_cnt = 0, link_flits = 0, cyc = 0, sink_mode = 0;
  logic [17:0] link_q[$];
  logic [17:0] out_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (tx_ctl[1:0] != 2'b00) begin
        link_flits++;
        chk(tx_ctl[3:2] == 2'b00, "R2", "reserved ctl bits", tx_ctl[3:2], 0);
        chk(cred_model > 0, "R4", "flit sent without credit", cred_model, 1);
        cred_model--;
        if (link_q.size() == 0) chk(0, "R3", "unexpected link flit", {tx_ctl[1:0], tx_phit}, 0);
        else begin
          logic [17:0] e;
          e = link_q.pop_front();
          chk({tx_ctl[1:0], tx_phit} == e, "R3", "link flit kind/data", {tx_ctl[1:0], tx_phit}, e);
        end
      end
      cred_model += int'(tx_credit);
      if (rx_ctl[1:0] != 2'b00) rx_in_cnt++;
      rx_ret_cnt += int'(rx_credit);
      case (sink_mode)
        0: dst_ready = 1'b1;
        1: dst_ready = cyc[0];
        2: dst_ready = (cyc % 4 == 0);
        default: dst_ready = 1'b0;
      endcase
      if (dst_valid && dst_ready) begin
        if (out_q.size() == 0) chk(0, "R6", "unexpected output beat", dst_data, 0);
        else begin
          logic [17:0] e;
          e = out_q.pop_front();
          chk({dst_first, dst_last, dst_data} == e, "R6", "output beat first/last/data",
              {dst_first, dst_last, dst_data}, e);
        end
      end
    end
  end

  task automatic send_pkt(input logic [15:0] tag, input int n, input int seed);
    link_q.push_back({2'b01, tag});
    out_q.push_back({2'b10, tag});
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = 16'((seed * 37 + i * 5 + 1) & 16'hffff);
      link_q.push_back({(i == n - 1) ? 2'b11 : 2'b10, d});
      out_q.push_back({1'b0, i == n - 1, d});
    end
    @(negedge clk);
    src_valid = 1'b1;
    src_tag = tag;
    for (int i = 0; i < n; i++) begin
      src_data = 16'((seed * 37 + i * 5 + 1) & 16'hffff);
      src_last = (i == n - 1);
      while (!src_ready) @(negedge clk);
      @(negedge clk);
    end
    src_valid = 1'b0;
    src_last = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((link_q.size() != 0 || out_q.size() != 0) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ctl == 4'd0, "R1", "tx ctl idle", tx_ctl, 0);
    chk(!src_ready, "R1", "src_ready low", src_ready, 0);
    chk(!dst_valid, "R1", "dst_valid low", dst_valid, 0);
    chk(!frame_err, "R1", "frame_err low", frame_err, 0);
    chk(rx_credit == 4'd0, "R1", "rx_credit zero", rx_credit, 0);
    // R5 no source data -> idle
    repeat (3) @(negedge clk);
    chk(link_flits == 0 && tx_ctl == 4'd0, "R5", "idle with no source", link_flits, 0);

    for (int m = 0; m < 3; m++) begin
      sink_mode = m;
      for (int n = 1; n <= 6; n++) send_pkt(16'(m * 256 + n + 16'h1000), n, m * 10 + n);
      drain();
      chk(link_q.size() == 0, "R3", "all link flits seen", link_q.size(), 0);
      chk(out_q.size() == 0, "R6", "all beats delivered", out_q.size(), 0);
      chk(cred_model == DEPTH, "R4", "credits restored", cred_model, DEPTH);
      chk(rx_ret_cnt == rx_in_cnt, "R7", "credit per flit", rx_ret_cnt, rx_in_cnt);
      chk(!frame_err, "R8", "no error on legal traffic", frame_err, 0);
    end

    // R9 stalled sink: blocks after DEPTH flits
    begin
      int base;
      logic [15:0] held;
      base = link_flits;
      sink_mode = 3;
      fork
        send_pkt(16'hABCD, 8, 99);
      join_none
      repeat (40) @(negedge clk);
      chk(link_flits - base == DEPTH, "R9", "flits before block", link_flits - base, DEPTH);
      chk(cred_model == 0, "R4", "credits exhausted", cred_model, 0);
      chk(tx_ctl == 4'd0, "R5", "idle without credit", tx_ctl, 0);
      chk(dst_valid, "R9", "output valid while stalled", dst_valid, 1);
      held = dst_data;
      repeat (3) @(negedge clk);
      chk(dst_valid && dst_data == held, "R9", "output held", dst_data, held);
      sink_mode = 0;
      wait fork;
      drain();
      chk(out_q.size() == 0, "R9", "stalled packet delivered", out_q.size(), 0);
      chk(cred_model == DEPTH, "R4", "credits restored after stall", cred_model, DEPTH);
      chk(rx_ret_cnt == rx_in_cnt, "R7", "credit per flit after stall", rx_ret_cnt, rx_in_cnt);
    end

    // R8 stray flits
    blk = 1'b1;
    @(negedge clk);
    inj = 1'b1; inj_ctl = 4'b0010; inj_phit = 16'h1234;
    @(negedge clk);
    chk(frame_err, "R8", "error after stray body", frame_err, 1);
    inj_ctl = 4'b0011; inj_phit = 16'h4321;
    @(negedge clk);
    inj_ctl = 4'b0000;
    @(negedge clk);
    chk(!dst_valid, "R8", "stray flits discarded", dst_valid, 0);
    out_q.push_back({2'b10, 16'h0077});
    out_q.push_back({2'b01, 16'h0055});
    inj_ctl = 4'b0001; inj_phit = 16'h0077;
    @(negedge clk);
    inj_ctl = 4'b0011; inj_phit = 16'h0055;
    @(negedge clk);
    inj = 1'b0; inj_ctl = 4'b0000;
    drain();
    blk = 1'b0;
    chk(out_q.size() == 0, "R6", "packet after error delivered", out_q.size(), 0);
    chk(frame_err, "R8", "error sticky", frame_err, 1);
    chk(rx_ret_cnt == rx_in_cnt, "R7", "credits for dropped flits", rx_ret_cnt, rx_in_cnt);
    finish_run();
  end
endmodule